// File: doc/BRIEF.md
# EDO DRAM data-pin direction and hold controller

This block is the device-side logic of an extended-data-out DRAM that decides, clock by clock, what happens on the shared data pins. The pins can be driven with read data, released to high impedance, or sampled as write data. The row strobe, column strobe, write enable and output enable (all active low) are registered once per clock. A second register stage turns them into falling-edge events. A small state machine then decides whether the pins drive, float or stay parked. Read data from the array is latched when a read column cycle opens. That value is held on the pins after the column strobe rises, which gives the extended-data-out behaviour. Output-enable pulses and write-enable pulses can park the pins in high impedance. Once parked, the pins stay floating until a new read column cycle starts. A write strobe pulses for one clock with the input data taken at the later of the write-enable fall and the column-strobe fall. No write occurs if output enable is still asserted when write enable falls late.

Every strobe change reaches the outputs exactly two clocks after the edge on which it is first sampled. The controller has six states:

- IDLE: the pins float.
- RD_ON: column strobe low in a read; the pins drive.
- RD_GAP: column strobe low in a read with output enable high; the pins float for now.
- HOLD_ON: column strobe high after a read; the pins keep driving.
- PARKED: the pins float until the next read column fall.
- WRITE: a write column cycle; the pins float.

The transitions are named as follows:

- both_high: row and column strobes both high; goes to IDLE from any state.
- refresh_fall: column strobe falls while the row strobe is high; goes to IDLE.
- rd_open: column strobe falls with write enable high; goes to RD_ON, or to RD_GAP if output enable is high.
- wr_open: column strobe falls with write enable low; goes to WRITE.
- we_park: write enable falls while the column strobe is high; goes to PARKED.
- late_wr: write enable falls during a read column cycle with output enable high; goes to WRITE.
- oe_gap: RD_ON to RD_GAP.
- oe_back: RD_GAP to RD_ON.
- cas_hold: RD_ON to HOLD_ON.
- gap_park: RD_GAP to PARKED when the column strobe rises.
- hold_park: HOLD_ON to PARKED when output enable rises.

Top module: `edo_dq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, dq_oe and wr_stb are 0 and dq_out is 0.
- R2: A column-strobe fall with the row strobe low, write enable high and output enable low sets dq_oe to 1. dq_out then equals rd_data as it was sampled with that fall. Both appear two clocks after the fall is first sampled.
- R3: After the column strobe rises with the row strobe and output enable still low, dq_oe stays 1 and dq_out keeps the latched value, even when rd_data changes. dq_out changes only after a read column-strobe fall.
- R4: Output enable going high while both strobes are low floats the pins. Output enable returning low before the column strobe rises drives the same latched data again. dq_oe is never 1 unless output enable was low two clocks earlier.
- R5: Output enable going high while the column strobe is high and the row strobe is low parks the pins. They stay floating when output enable returns low, until a read column-strobe fall.
- R6: Write enable falling while the column strobe is high parks the pins. They stay floating after write enable rises, until the column strobe falls with write enable high.
- R7: A column-strobe fall with write enable already low (early write) keeps dq_oe at 0 whatever output enable does. It gives one wr_stb pulse whose wr_data equals dq_in as sampled with that fall. wr_stb is never 1 while dq_oe is 1.
- R8: In a read column cycle with output enable high, a write-enable fall gives one wr_stb pulse with wr_data equal to dq_in sampled with that fall. The pulse lasts exactly one clock.
- R9: A write-enable fall during a column cycle while output enable is still low gives no wr_stb. dq_oe stays 1 with the same read data.
- R10: Once both the row and column strobes are sampled high, dq_oe is 0 two clocks later.
- R11: A column-strobe fall while the row strobe is high gives neither drive nor write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DW | Read data from the array for the addressed column |
| dq_in | input | DW | Data presented on the pins by the host |
| dq_oe | output | 1 | 1 when the data pins are driven |
| dq_out | output | DW | Latched read data for the pins |
| wr_stb | output | 1 | One-clock pulse that commits a write |
| wr_data | output | DW | Write data latched with wr_stb |

## Verification
A wrong state in this block shows up at the pins two clocks after the strobe change that caused it. The failure takes one of three forms: dq_oe is 1 where the pins should float, or 0 where data should hold, or dq_out shows a value other than the one latched at the last read column fall. A lost park flag shows up only at the first output-enable or write-enable return after the park. Because of that, the bench checks dq_oe again after each strobe returns, and not only right after it moves. A bad write decision shows up as a missing, doubled or misdated wr_stb pulse in the same two-clock window.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ON   = 3'd1,
        ST_RD_GAP  = 3'd2,
        ST_HOLD_ON = 3'd3,
        ST_PARKED  = 3'd4,
        ST_WRITE   = 3'd5
    } dq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler
    import edo_dq_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       raw,
    input  logic [DW-1:0] rd_raw,
    input  logic [DW-1:0] dq_raw,
    output strobe_t       cur,
    output logic          cas_fall,
    output logic          we_fall,
    output logic [DW-1:0] cur_rd,
    output logic [DW-1:0] cur_dq
);

    localparam strobe_t IDLE_LEVELS = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    strobe_t prev;

    // first stage: capture of the pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= IDLE_LEVELS;
            cur_rd <= '0;
            cur_dq <= '0;
        end else begin
            cur    <= raw;
            cur_rd <= rd_raw;
            cur_dq <= dq_raw;
        end
    end

    // second stage: previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= IDLE_LEVELS;
        end else begin
            prev <= cur;
        end
    end

    assign cas_fall = prev.cas_n & ~cur.cas_n;
    assign we_fall  = prev.we_n  & ~cur.we_n;

endmodule

// File: rtl/edo_dq_fsm.sv
module edo_dq_fsm
    import edo_dq_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       cur,
    input  logic          cas_fall,
    input  logic          we_fall,
    input  logic [DW-1:0] cur_rd,
    output dq_state_e     state,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out
);

    dq_state_e nxt;
    logic      rd_cycle;
    logic      both_high;
    logic      rd_open;
    logic [DW-1:0] held_q;

    assign rd_cycle  = (state == ST_RD_ON) || (state == ST_RD_GAP);
    assign both_high = cur.ras_n && cur.cas_n;
    assign rd_open   = cas_fall && !cur.ras_n && cur.we_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions, in priority order
    always_comb begin
        nxt = state;
        if (both_high) begin
            nxt = ST_IDLE;                               // both_high
        end else if (cas_fall) begin
            if (cur.ras_n) begin
                nxt = ST_IDLE;                           // refresh_fall
            end else if (!cur.we_n) begin
                nxt = ST_WRITE;                          // wr_open
            end else if (cur.oe_n) begin
                nxt = ST_RD_GAP;                         // rd_open, enable off
            end else begin
                nxt = ST_RD_ON;                          // rd_open
            end
        end else if (we_fall && cur.cas_n) begin
            nxt = ST_PARKED;                             // we_park
        end else if (we_fall && !cur.ras_n && cur.oe_n && rd_cycle) begin
            nxt = ST_WRITE;                              // late_wr
        end else begin
            unique case (state)
                ST_RD_ON: begin
                    if (cur.oe_n) begin
                        nxt = ST_RD_GAP;                 // oe_gap
                    end else if (cur.cas_n) begin
                        nxt = ST_HOLD_ON;                // cas_hold
                    end
                end
                ST_RD_GAP: begin
                    if (cur.cas_n) begin
                        nxt = ST_PARKED;                 // gap_park
                    end else if (!cur.oe_n) begin
                        nxt = ST_RD_ON;                  // oe_back
                    end
                end
                ST_HOLD_ON: begin
                    if (cur.oe_n) begin
                        nxt = ST_PARKED;                 // hold_park
                    end
                end
                ST_IDLE, ST_PARKED, ST_WRITE: begin
                    nxt = state;
                end
                default: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end

    // read data latch: loaded only when a read column cycle opens
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (rd_open) begin
            held_q <= cur_rd;
        end
    end

    // outputs from the state alone
    always_comb begin
        dq_oe = 1'b0;
        unique case (state)
            ST_RD_ON, ST_HOLD_ON: dq_oe = 1'b1;
            ST_IDLE, ST_RD_GAP, ST_PARKED, ST_WRITE: dq_oe = 1'b0;
            default: dq_oe = 1'b0;
        endcase
    end

    assign dq_out = held_q;

endmodule

// File: rtl/edo_write_capture.sv
module edo_write_capture
    import edo_dq_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       cur,
    input  logic          cas_fall,
    input  logic          we_fall,
    input  dq_state_e     state,
    input  logic [DW-1:0] cur_dq,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);

    logic early_hit;
    logic late_hit;
    logic rd_cycle;

    assign rd_cycle  = (state == ST_RD_ON) || (state == ST_RD_GAP);
    // write enable already low when the column strobe falls
    assign early_hit = cas_fall && !cur.ras_n && !cur.we_n;
    // write enable falls inside a read column cycle with the output released
    assign late_hit  = we_fall && !cas_fall && !cur.cas_n && !cur.ras_n
                       && cur.oe_n && rd_cycle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_stb <= early_hit || late_hit;
            if (early_hit || late_hit) begin
                wr_data <= cur_dq;
            end
        end
    end

endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl
    import edo_dq_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);

    strobe_t       raw;
    strobe_t       cur;
    logic          cas_fall;
    logic          we_fall;
    logic [DW-1:0] cur_rd;
    logic [DW-1:0] cur_dq;
    dq_state_e     state;

    assign raw = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};

    edo_strobe_sampler #(.DW(DW)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw),
        .rd_raw   (rd_data),
        .dq_raw   (dq_in),
        .cur      (cur),
        .cas_fall (cas_fall),
        .we_fall  (we_fall),
        .cur_rd   (cur_rd),
        .cur_dq   (cur_dq)
    );

    edo_dq_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (cur),
        .cas_fall (cas_fall),
        .we_fall  (we_fall),
        .cur_rd   (cur_rd),
        .state    (state),
        .dq_oe    (dq_oe),
        .dq_out   (dq_out)
    );

    edo_write_capture #(.DW(DW)) u_wcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (cur),
        .cas_fall (cas_fall),
        .we_fall  (we_fall),
        .state    (state),
        .cur_dq   (cur_dq),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic          wr_stb
);

    assert_off_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n, 2) && $past(cas_n, 2)) |-> !dq_oe);

    assert_oe_gates_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(oe_n, 2));

    assert_data_only_on_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dq_out) |-> ($past(cas_n, 3) && !$past(cas_n, 2) && !$past(ras_n, 2)));

    assert_wr_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !dq_oe);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_refresh_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n, 2) && $past(cas_n, 3) && !$past(cas_n, 2)) |-> (!wr_stb && !dq_oe));

endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/edo_dq_ctrl_tb.sv
module edo_dq_ctrl_tb;

    localparam int DW = 4;
    localparam int NV = 1 << DW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ras_n, cas_n, we_n, oe_n;
    logic [DW-1:0] rd_data, dq_in;
    logic          dq_oe, wr_stb;
    logic [DW-1:0] dq_out, wr_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    edo_dq_ctrl #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .rd_data(rd_data), .dq_in(dq_in), .dq_oe(dq_oe), .dq_out(dq_out),
        .wr_stb(wr_stb), .wr_data(wr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, let two rising edges pass, return at a falling edge
    task automatic apply(input logic r, input logic c, input logic w, input logic o);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
        rd_data = '0; dq_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dq_oe", dq_oe, 0);
        chk("R1 wr_stb", wr_stb, 0);
        chk("R1 dq_out", dq_out, 0);

        // R2, R3, R10: read with hold, swept over every data value
        for (int v = 0; v < NV; v++) begin
            int rv;
            rv = (v * 5 + 3) % NV;
            rd_data = DW'(rv);
            apply(0, 1, 1, 0);
            apply(0, 0, 1, 0);
            chk("R2 drive", dq_oe, 1);
            chk("R2 data", dq_out, rv);
            rd_data = DW'((NV - 1) - rv);
            apply(0, 1, 1, 0);
            chk("R3 hold drive", dq_oe, 1);
            chk("R3 hold data", dq_out, rv);
            apply(1, 1, 1, 0);
            chk("R10 both high off", dq_oe, 0);
        end

        // R4: output enable pulse inside the column cycle, then R5 park
        rd_data = 4'd9;
        apply(0, 1, 1, 0);
        apply(0, 0, 1, 0);
        rd_data = 4'd3;
        apply(0, 0, 1, 1);
        chk("R4 gap off", dq_oe, 0);
        apply(0, 0, 1, 0);
        chk("R4 back on", dq_oe, 1);
        chk("R4 same data", dq_out, 9);
        apply(0, 1, 1, 0);
        chk("R3 hold after gap", dq_oe, 1);
        apply(0, 1, 1, 1);
        chk("R5 park", dq_oe, 0);
        apply(0, 1, 1, 0);
        chk("R5 stays parked", dq_oe, 0);
        chk("R5 data unchanged", dq_out, 9);
        rd_data = 4'd6;
        apply(0, 0, 1, 0);
        chk("R5 cleared by read", dq_oe, 1);
        chk("R5 new data", dq_out, 6);
        apply(1, 1, 1, 1);

        // R6: write enable pulse while column strobe is high
        rd_data = 4'd5;
        apply(0, 1, 1, 0);
        apply(0, 0, 1, 0);
        apply(0, 1, 1, 0);
        chk("R6 hold before", dq_oe, 1);
        apply(0, 1, 0, 0);
        chk("R6 park", dq_oe, 0);
        chk("R6 no write", wr_stb, 0);
        apply(0, 1, 1, 0);
        chk("R6 stays parked", dq_oe, 0);
        rd_data = 4'd12;
        apply(0, 0, 1, 0);
        chk("R6 cleared", dq_oe, 1);
        chk("R6 data", dq_out, 12);
        apply(1, 1, 1, 1);

        // R7: early writes swept over every data value, output enable low
        for (int v = 0; v < NV; v++) begin
            int wv;
            wv = (v * 7 + 1) % NV;
            apply(0, 1, 1, 1);
            apply(0, 1, 0, 0);
            dq_in = DW'(wv);
            apply(0, 0, 0, 0);
            chk("R7 float", dq_oe, 0);
            chk("R7 strobe", wr_stb, 1);
            chk("R7 data", wr_data, wv);
            dq_in = DW'(~wv);
            apply(0, 1, 0, 0);
            chk("R7 single", wr_stb, 0);
            chk("R7 still float", dq_oe, 0);
            apply(1, 1, 1, 1);
        end

        // R8: late writes with output enable high
        for (int v = 0; v < NV; v++) begin
            apply(0, 1, 1, 1);
            apply(0, 0, 1, 1);
            chk("R8 gap", dq_oe, 0);
            dq_in = DW'(NV - 1 - v);
            apply(0, 0, 0, 1);
            chk("R8 strobe", wr_stb, 1);
            chk("R8 data", wr_data, NV - 1 - v);
            chk("R8 float", dq_oe, 0);
            apply(0, 1, 1, 1);
            chk("R8 one clock", wr_stb, 0);
            apply(1, 1, 1, 1);
        end

        // R9: late write attempted with output enable low
        rd_data = 4'd7;
        dq_in = 4'd2;
        apply(0, 1, 1, 0);
        apply(0, 0, 1, 0);
        apply(0, 0, 0, 0);
        chk("R9 no write", wr_stb, 0);
        chk("R9 drive", dq_oe, 1);
        chk("R9 data", dq_out, 7);
        apply(1, 1, 1, 1);

        // R11: column fall before row fall
        rd_data = 4'd10;
        apply(1, 0, 1, 0);
        chk("R11 no drive", dq_oe, 0);
        chk("R11 no write", wr_stb, 0);
        apply(0, 0, 1, 0);
        chk("R11 still off", dq_oe, 0);
        chk("R11 data kept", dq_out, 7);
        apply(1, 1, 1, 1);
        chk("R10 final off", dq_oe, 0);

        finish_run();
    end

endmodule